// File: doc/BRIEF.md
# Prefixed Instruction Group Layout Parser

This block sits in a front end that fetches long instruction groups as a stream of 16-bit halfwords. The first halfword of each group is a prefix. It carries a marker, a length code, a flag for an optional vector-length block, two table sizes and an entry-width mode bit. The parser decodes the prefix and works out how long the group is. It then labels every halfword of the group, as it passes, with the section it belongs to: the header, the vector-length block, the register-qualifier table, the predicate-qualifier table, or the payload opcode space.

The halfword stream passes straight through. The output side sees each halfword in the same cycle, together with:
- its section tag;
- an index within that section;
- byte-lane padding flags for narrow register entries;
- a last flag on the group's final halfword;
- an error code.

While a group is in flight, the decoded entry counts, the payload start offset and the group length are held steady on side outputs. A one-cycle done strobe marks the end of each well-formed group.

The parser does not interpret the payload opcodes or the qualifier entries. It only places them.

Top module: `vpg_group_parser`

## Requirements
- R1: The first halfword after reset, and the first halfword after any group ends, is taken as a prefix and tagged HDR (tag code 0). If its bits 6:0 are not all ones, the beat carries error code 1 (not a prefix) and last=1, and the next halfword is again taken as a prefix.
- R2: A well-marked prefix whose length code (bits 14:12) is 7 carries error code 2 and last=1 on that beat.
- R3: A valid group is 5 + n halfwords long, where n is the length code. out_last is high only on the halfword at offset 4 + n, counted from the prefix at offset 0.
- R4: When prefix bit 15 is 1, the halfword at offset 1 is tagged VL (tag code 1). When bit 15 is 0, no halfword is tagged VL.
- R5: Prefix bits 9:8 give r. The r halfwords after the optional VL block are tagged REG (code 2). Their out_idx is the index of the first entry in that halfword: 0,1,2 in wide mode (prefix bit 7 = 1), and 0,2,4 in narrow mode (bit 7 = 0, two 8-bit entries per halfword, low byte first).
- R6: Prefix bits 11:10 give p. The p halfwords after the register table are tagged PRED (code 3), with out_idx numbered as in R5.
- R7: Throughout a valid group, reg_entries and pred_entries equal r and p in wide mode, and 2r and 2p in narrow mode.
- R8: On a narrow-mode REG halfword, out_pad[b] is 1 exactly when byte lane b (bits 8b+7:8b) is 0x00. On every other halfword out_pad is 0.
- R9: Every halfword from offset payload_off = 1 + bit15 + r + p up to the end of the group is tagged OP (code 4), with out_idx counting 0,1,2... from the first payload halfword. grp_len reports 5 + n.
- R10: If 1 + bit15 + r + p is at least 5 + n, the prefix beat carries error code 3 and last=1, and no halfword is tagged OP for that group.
- R11: out_valid follows in_valid and in_ready follows out_ready in the same cycle. The parser advances only on a cycle where both in_valid and out_ready are high, so stalls repeat the same labelling.
- R12: grp_done is high exactly on the accepted last halfword of a group with error code 0.
- R13: Asserting rst in the middle of a group abandons it, and the next accepted halfword is treated as a prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input halfword valid |
| in_ready | output | 1 | Parser can accept the halfword |
| in_data | input | 16 | Input halfword |
| out_valid | output | 1 | Tagged halfword valid |
| out_ready | input | 1 | Downstream accepts the tagged halfword |
| out_data | output | 16 | Halfword passed through |
| out_tag | output | 3 | Section: 0 HDR, 1 VL, 2 REG, 3 PRED, 4 OP |
| out_idx | output | 4 | Entry index (REG/PRED) or payload halfword index (OP) |
| out_pad | output | 2 | Per byte lane: narrow register entry is unused (0x00) |
| out_last | output | 1 | Final halfword of the group |
| out_err | output | 2 | 0 none, 1 not a prefix, 2 reserved length, 3 no payload room |
| grp_done | output | 1 | Accepted last halfword of a well-formed group |
| reg_entries | output | 3 | Number of register entries in the group |
| pred_entries | output | 3 | Number of predicate entries in the group |
| payload_off | output | 4 | Offset of the first payload halfword from the prefix |
| grp_len | output | 4 | Group length in halfwords |

## Verification
Each halfword is tagged from a position counter and a held copy of the decoded prefix, so a wrong internal state shows up at the ports on the very next accepted halfword. A counter that has slipped shifts the VL, REG, PRED and OP boundaries and moves out_last. A stale or corrupted layout changes the entry counts and the payload offset. A parser that does not go back to prefix mode puts a non-HDR tag on the next group's first halfword. The reference model rebuilds the expected labelling of every group from the prefix fields alone. It compares every accepted halfword under random input gaps and output stalls, which also exposes advancing on a cycle without a handshake.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

    localparam int HW_BITS   = 16;
    localparam int LANES     = HW_BITS / 8;
    localparam int LEN_W     = 4;
    localparam int IDX_W     = LEN_W;
    localparam int CODE_W    = 3;
    localparam int CNT_FLD_W = 2;
    localparam int ENT_W     = CNT_FLD_W + 1;
    localparam int MARK_W    = 7;
    localparam int BASE_HW   = 5;

    localparam int B_VL      = 15;
    localparam int B_CODE_LO = 12;
    localparam int B_PC_LO   = 10;
    localparam int B_RC_LO   = 8;
    localparam int B_WIDE    = 7;

    localparam logic [MARK_W-1:0] MARK          = '1;
    localparam logic [CODE_W-1:0] CODE_RESERVED = '1;

    typedef enum logic [2:0] {
        SEC_HDR  = 3'd0,
        SEC_VL   = 3'd1,
        SEC_REG  = 3'd2,
        SEC_PRED = 3'd3,
        SEC_OP   = 3'd4
    } sec_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_NOTPFX = 2'd1,
        ERR_BADLEN = 2'd2,
        ERR_NOROOM = 2'd3
    } err_e;

    typedef struct packed {
        logic                 vl;
        logic                 wide;
        logic [CNT_FLD_W-1:0] rc;
        logic [CNT_FLD_W-1:0] pc;
        logic [LEN_W-1:0]     tot;
        logic [LEN_W-1:0]     body;
    } layout_t;

    function automatic layout_t unpack_prefix(input logic [HW_BITS-1:0] h);
        layout_t l;
        l.vl   = h[B_VL];
        l.wide = h[B_WIDE];
        l.rc   = h[B_RC_LO +: CNT_FLD_W];
        l.pc   = h[B_PC_LO +: CNT_FLD_W];
        l.tot  = LEN_W'(BASE_HW) + LEN_W'(h[B_CODE_LO +: CODE_W]);
        l.body = LEN_W'(1) + LEN_W'(h[B_VL]) + LEN_W'(l.rc) + LEN_W'(l.pc);
        return l;
    endfunction

    function automatic logic [ENT_W-1:0] entry_count(input logic [CNT_FLD_W-1:0] f,
                                                     input logic wide);
        return wide ? ENT_W'(f) : {f, 1'b0};
    endfunction

endpackage

// File: rtl/vpg_prefix_dec.sv
module vpg_prefix_dec
    import vpg_pkg::*;
(
    input  logic [HW_BITS-1:0] hw,
    output layout_t            lay,
    output err_e               err
);

    logic marked;
    logic bad_code;
    logic no_room;

    always_comb begin
        lay      = unpack_prefix(hw);
        marked   = (hw[MARK_W-1:0] == MARK);
        bad_code = (hw[B_CODE_LO +: CODE_W] == CODE_RESERVED);
        no_room  = (lay.body >= lay.tot);
        if (!marked)        err = ERR_NOTPFX;
        else if (bad_code)  err = ERR_BADLEN;
        else if (no_room)   err = ERR_NOROOM;
        else                err = ERR_NONE;
    end

endmodule

// File: rtl/vpg_pos_ctrl.sv
module vpg_pos_ctrl
    import vpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             last,
    input  err_e             dec_err,
    input  layout_t          dec_lay,
    output logic             busy,
    output logic [LEN_W-1:0] pos,
    output layout_t          held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pos  <= '0;
            held <= '0;
        end else if (fire) begin
            if (!busy) begin
                if (dec_err == ERR_NONE) begin
                    busy <= 1'b1;
                    pos  <= LEN_W'(1);
                    held <= dec_lay;
                end
            end else if (last) begin
                busy <= 1'b0;
                pos  <= '0;
            end else begin
                pos <= pos + LEN_W'(1);
            end
        end
    end

    // R11: no handshake, no movement
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire) |=> (busy && $stable(pos)));

    // R3: offset never reaches the group length
    a_r3_pos_below_len: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pos < held.tot));

    // R10: a group is entered only when payload room exists
    a_r10_room_on_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (held.body < held.tot));

endmodule

// File: rtl/vpg_beat_tag.sv
module vpg_beat_tag
    import vpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [LEN_W-1:0]   pos,
    input  layout_t            lay,
    input  logic [HW_BITS-1:0] data,
    output sec_e               tag,
    output logic [IDX_W-1:0]   idx,
    output logic [LANES-1:0]   pad,
    output logic               last
);

    logic [LEN_W-1:0] vl_end;
    logic [LEN_W-1:0] reg_end;
    logic [LEN_W-1:0] k;

    always_comb begin
        vl_end  = LEN_W'(1) + LEN_W'(lay.vl);
        reg_end = vl_end + LEN_W'(lay.rc);
        k       = '0;
        if (pos == '0) begin
            tag = SEC_HDR;
        end else if (pos < vl_end) begin
            tag = SEC_VL;
        end else if (pos < reg_end) begin
            tag = SEC_REG;
            k   = pos - vl_end;
        end else if (pos < lay.body) begin
            tag = SEC_PRED;
            k   = pos - reg_end;
        end else begin
            tag = SEC_OP;
            k   = pos - lay.body;
        end
        if ((tag == SEC_REG || tag == SEC_PRED) && !lay.wide)
            idx = IDX_W'(k << 1);
        else
            idx = IDX_W'(k);
        last = (pos == lay.tot - LEN_W'(1));
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign pad[b] = (tag == SEC_REG) && !lay.wide && (data[8*b +: 8] == 8'h00);
    end

    // R4: the VL section is a single slot right after the prefix
    a_r4_vl_slot: assert property (@(posedge clk) disable iff (rst)
        (valid && tag == SEC_VL) |-> (pos == LEN_W'(1) && lay.vl));

    // R8: padding is only flagged on narrow register halfwords
    a_r8_pad_scope: assert property (@(posedge clk) disable iff (rst)
        (valid && pad != '0) |-> (tag == SEC_REG && !lay.wide));

endmodule

// File: rtl/vpg_group_parser.sv
module vpg_group_parser
    import vpg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [15:0]  in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [15:0]  out_data,
    output logic [2:0]   out_tag,
    output logic [3:0]   out_idx,
    output logic [1:0]   out_pad,
    output logic         out_last,
    output logic [1:0]   out_err,
    output logic         grp_done,
    output logic [2:0]   reg_entries,
    output logic [2:0]   pred_entries,
    output logic [3:0]   payload_off,
    output logic [3:0]   grp_len
);

    layout_t          dec_lay;
    err_e             dec_err;
    logic             busy;
    logic [LEN_W-1:0] pos;
    layout_t          held;
    layout_t          cur_lay;
    err_e             cur_err;
    sec_e             tag;
    logic [IDX_W-1:0] idx;
    logic [LANES-1:0] pad;
    logic             pos_last;
    logic             last;
    logic             fire;

    vpg_prefix_dec u_dec (
        .hw  (in_data),
        .lay (dec_lay),
        .err (dec_err)
    );

    assign cur_lay = busy ? held : dec_lay;
    assign cur_err = busy ? ERR_NONE : dec_err;
    assign fire    = in_valid && out_ready;
    assign last    = (cur_err != ERR_NONE) || pos_last;

    vpg_pos_ctrl u_pos (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .last    (last),
        .dec_err (dec_err),
        .dec_lay (dec_lay),
        .busy    (busy),
        .pos     (pos),
        .held    (held)
    );

    vpg_beat_tag u_tag (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .pos   (pos),
        .lay   (cur_lay),
        .data  (in_data),
        .tag   (tag),
        .idx   (idx),
        .pad   (pad),
        .last  (pos_last)
    );

    assign in_ready     = out_ready;
    assign out_valid    = in_valid;
    assign out_data     = in_data;
    assign out_tag      = tag;
    assign out_idx      = idx;
    assign out_pad      = pad;
    assign out_last     = last;
    assign out_err      = cur_err;
    assign grp_done     = fire && last && (cur_err == ERR_NONE);
    assign reg_entries  = entry_count(cur_lay.rc, cur_lay.wide);
    assign pred_entries = entry_count(cur_lay.pc, cur_lay.wide);
    assign payload_off  = cur_lay.body;
    assign grp_len      = cur_lay.tot;

    // R10: an errored prefix closes its group at once
    a_r10_err_closes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_err != ERR_NONE) |-> (out_last && out_tag == SEC_HDR));

    // R2: reserved length code on a marked prefix is reported
    a_r2_badlen: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && in_data[MARK_W-1:0] == MARK
         && in_data[B_CODE_LO +: CODE_W] == CODE_RESERVED) |-> (out_err == ERR_BADLEN));

    // R12: completion strobe only on a clean final halfword
    a_r12_done_last: assert property (@(posedge clk) disable iff (rst)
        grp_done |-> (out_last && out_err == ERR_NONE && fire));

    // R1: after an accepted last halfword the next beat is a prefix again
    a_r1_rearm: assert property (@(posedge clk) disable iff (rst)
        (fire && out_last) |=> !busy);

endmodule

// File: tb/sim_vpg_group_parser.sv
module sim_vpg_group_parser;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic [2:0]  out_tag;
    logic [3:0]  out_idx;
    logic [1:0]  out_pad;
    logic        out_last;
    logic [1:0]  out_err;
    logic        grp_done;
    logic [2:0]  reg_entries;
    logic [2:0]  pred_entries;
    logic [3:0]  payload_off;
    logic [3:0]  grp_len;

    int checks = 0;
    int fails  = 0;
    int gap_pct   = 0;
    int stall_pct = 0;

    always #4 clk = ~clk;

    vpg_group_parser u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_tag(out_tag), .out_idx(out_idx), .out_pad(out_pad),
        .out_last(out_last), .out_err(out_err), .grp_done(grp_done),
        .reg_entries(reg_entries), .pred_entries(pred_entries),
        .payload_off(payload_off), .grp_len(grp_len)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic logic [15:0] mk(input int vl, input int n, input int pc,
                                       input int rc, input int wide);
        return {vl[0], n[2:0], pc[1:0], rc[1:0], wide[0], 7'h7F};
    endfunction

    function automatic int grp_error(input logic [15:0] h);
        int hdr;
        if (h[6:0] != 7'h7F) return 1;
        if (h[14:12] == 3'd7) return 2;
        hdr = 1 + int'(h[15]) + int'(h[9:8]) + int'(h[11:10]);
        if (hdr >= 5 + int'(h[14:12])) return 3;
        return 0;
    endfunction

    // Expected labelling of the halfword at offset p of the group led by h
    task automatic expect_beat(input logic [15:0] h, input int p, input logic [15:0] d,
                               output int tag, output int idx, output int pad,
                               output int last);
        int vl, rc, pc, tot, wide, s;
        vl = int'(h[15]); rc = int'(h[9:8]); pc = int'(h[11:10]);
        wide = int'(h[7]); tot = 5 + int'(h[14:12]);
        tag = 0; idx = 0; pad = 0; last = 0;
        if (grp_error(h) != 0) begin
            last = 1;
            return;
        end
        last = (p == tot - 1);
        s = p;
        if (s == 0) begin tag = 0; return; end
        s -= 1;
        if (vl == 1) begin
            if (s == 0) begin tag = 1; return; end
            s -= 1;
        end
        if (s < rc) begin
            tag = 2;
            idx = wide ? s : 2 * s;
            if (!wide) pad = ((d[15:8] == 8'h00) ? 2 : 0) + ((d[7:0] == 8'h00) ? 1 : 0);
            return;
        end
        s -= rc;
        if (s < pc) begin
            tag = 3;
            idx = wide ? s : 2 * s;
            return;
        end
        s -= pc;
        tag = 4;
        idx = s;
    endtask

    task automatic run_group(input logic [15:0] h);
        int e, tot, etag, eidx, epad, elast, mult;
        logic [15:0] d;
        bit done;
        e    = grp_error(h);
        tot  = (e != 0) ? 1 : 5 + int'(h[14:12]);
        mult = h[7] ? 1 : 2;
        for (int p = 0; p < tot; p++) begin
            if (p == 0) d = h;
            else begin
                d[7:0]  = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
                d[15:8] = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
            end
            expect_beat(h, p, d, etag, eidx, epad, elast);
            done = 1'b0;
            while (!done) begin
                @(negedge clk);
                in_valid  = (($urandom % 100) >= gap_pct);
                in_data   = d;
                out_ready = (($urandom % 100) >= stall_pct);
                #1;
                chk(out_valid == in_valid, "R11", "out_valid", int'(out_valid), int'(in_valid));
                chk(in_ready == out_ready, "R11", "in_ready", int'(in_ready), int'(out_ready));
                if (in_valid && out_ready) begin
                    done = 1'b1;
                    chk(out_data == d, "R11", "out_data", int'(out_data), int'(d));
                    chk(int'(out_err) == (p == 0 ? e : 0),
                        (e == 1) ? "R1" : (e == 2) ? "R2" : "R10", "out_err",
                        int'(out_err), (p == 0 ? e : 0));
                    chk(int'(out_tag) == etag,
                        etag == 1 ? "R4" : etag == 2 ? "R5" : etag == 3 ? "R6" :
                        etag == 4 ? "R9" : "R1", "out_tag", int'(out_tag), etag);
                    if (etag >= 2)
                        chk(int'(out_idx) == eidx,
                            etag == 2 ? "R5" : etag == 3 ? "R6" : "R9", "out_idx",
                            int'(out_idx), eidx);
                    chk(int'(out_pad) == epad, "R8", "out_pad", int'(out_pad), epad);
                    chk(int'(out_last) == elast, "R3", "out_last", int'(out_last), elast);
                    chk(int'(grp_done) == ((elast == 1 && e == 0) ? 1 : 0), "R12",
                        "grp_done", int'(grp_done), (elast == 1 && e == 0) ? 1 : 0);
                    if (e == 0) begin
                        chk(int'(reg_entries) == mult * int'(h[9:8]), "R7", "reg_entries",
                            int'(reg_entries), mult * int'(h[9:8]));
                        chk(int'(pred_entries) == mult * int'(h[11:10]), "R7", "pred_entries",
                            int'(pred_entries), mult * int'(h[11:10]));
                        chk(int'(payload_off) == 1 + int'(h[15]) + int'(h[9:8]) + int'(h[11:10]),
                            "R9", "payload_off", int'(payload_off),
                            1 + int'(h[15]) + int'(h[9:8]) + int'(h[11:10]));
                        chk(int'(grp_len) == tot, "R9", "grp_len", int'(grp_len), tot);
                    end
                end else begin
                    chk(grp_done == 1'b0, "R12", "grp_done_idle", int'(grp_done), 0);
                end
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin : stim
        logic [15:0] h;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R13", "reset out_valid", int'(out_valid), 0);
        chk(grp_done == 1'b0, "R13", "reset grp_done", int'(grp_done), 0);
        @(negedge clk);
        rst = 1'b0;

        // directed groups: R3 R4 R5 R6 R8 R9
        run_group(mk(0, 0, 0, 0, 1));
        run_group(mk(1, 6, 3, 3, 1));
        run_group(mk(1, 6, 3, 3, 0));
        run_group(mk(0, 2, 1, 2, 0));
        run_group(mk(1, 3, 0, 0, 0));
        run_group(mk(0, 1, 2, 0, 1));
        // R10: header and tables fill the group
        run_group(mk(1, 0, 2, 1, 1));
        run_group(mk(0, 2, 3, 3, 0));
        // R2: reserved length code
        run_group(mk(0, 7, 0, 0, 1));
        // R1: unmarked first halfword, then a normal group follows
        run_group(16'h1234);
        run_group(mk(1, 2, 1, 1, 1));

        // R13: abandon a group part-way with reset
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1; in_data = mk(0, 6, 0, 0, 1);
        @(negedge clk);
        in_data = 16'h0000;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b1; in_data = mk(1, 1, 0, 1, 0);
        #1;
        chk(int'(out_tag) == 0, "R13", "tag after reset", int'(out_tag), 0);
        chk(int'(grp_len) == 6, "R13", "len after reset", int'(grp_len), 6);
        in_valid = 1'b0; out_ready = 1'b0;

        // R11: random gaps and stalls over random prefixes
        gap_pct = 30; stall_pct = 30;
        for (int g = 0; g < 80; g++) begin
            h = 16'($urandom);
            if (($urandom % 10) != 0) h[6:0] = 7'h7F;
            run_group(h);
        end
        gap_pct = 0; stall_pct = 0;
        run_group(mk(1, 5, 2, 2, 0));

        summary();
        $finish;
    end

endmodule